// File: doc/BRIEF.md
# Head-per-Track Disk Command Sequencer

This block is the programmed-I/O front end of a head-per-track disk controller. The processor reaches it through four single-cycle strobes: control, output, input and sense. Each strobe carries a function code. Output and input strobes move one data word. Control and output strobes can be rejected. Sense strobes answer with a skip when a tested condition is true.

A control strobe starts an operation, in DMA mode or in I/O-bus mode. The controller then takes two command words through the same output path. The first gives the direction, the surface and the track. The second gives a character address. The block checks the addresses in these words. It then hands a start request to the transfer engine, or it aborts with an access error.

The block keeps these flags: word ready, busy, data error, access error and end-of-range. It raises an interrupt request and, in DMA mode, pulses a channel request. The transfer engine signals back when a word is ready and when the operation is done.

Top module: `hpt_cmd_seq`

## Requirements
- R1: After synchronous active-low reset, the following are all 0: busy, word ready, end-of-range, data error, access error, interrupt, DMA mode, channel request and start valid. The sequencer is idle.
- R2: A control strobe with function 3 or 7 is a start request. Function 4 sets end-of-range and clears the interrupt. Any other control function asserts `reject` in the strobe cycle.
- R3: A start request while busy changes nothing. Otherwise it sets busy and word ready, clears end-of-range and both error flags, and makes the next accepted output word command word 1.
- R4: DMA mode is set by control function 3 only when `chan_assigned` is 1. In every other case DMA mode is 0. While in DMA mode, each setting of word ready is followed one cycle later by a one-cycle `chan_req` pulse.
- R5: An output strobe with function 0 while word ready is set skips. The word is latched onto `xfer_wdata`. In the command-word-1 state, word ready stays set. In the idle state, word ready is cleared. Output while not ready does not skip and leaves `xfer_wdata` unchanged.
- R6: An input strobe with function 0 while word ready is set skips. It returns the buffer word on `rdata` and clears word ready. Without ready it does not skip. A nonzero function on input or output asserts `reject`.
- R7: A sense strobe skips for these codes: 0 when word ready is set, 1 when not busy, 2 when there is no data error, 3 when there is no access error, and 4 when no interrupt is pending. All other codes never skip.
- R8: Command word 1 uses bit 15 for direction (1 write, 0 read), bits 13:10 for the surface and bits 9:4 for the track. Command word 2 uses bits 11:0 for the character address. The start request reports these four fields.
- R9: Command word 2 is rejected when any of these holds: the word address (character address >> 1) is 1536 or more; `unit_present` is 0; or the surface exceeds `surf_cnt_m1`. A rejected word sets access error, clears busy and word ready, and raises the interrupt. No start request is issued.
- R10: A valid command word 2 gives a one-cycle `start_vld` in the next cycle. Word ready is set for a write and cleared for a read.
- R11: `eng_rdy` sets word ready and, for a read, loads `eng_data` into the buffer. `eng_done` clears busy and raises the interrupt. If `eng_derr` is also high, data error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_stb | input | 1 | Control strobe |
| out_stb | input | 1 | Output (processor to block) strobe |
| in_stb | input | 1 | Input (block to processor) strobe |
| sense_stb | input | 1 | Sense strobe |
| func | input | 4 | Function code of the strobe |
| wdata | input | 16 | Output data word |
| rdata | output | 16 | Input data word, valid with an accepted input strobe |
| skip | output | 1 | Skip response in the strobe cycle |
| reject | output | 1 | Unsupported function in the strobe cycle |
| chan_assigned | input | 1 | A DMA channel is attached |
| unit_present | input | 1 | Disk unit is present |
| surf_cnt_m1 | input | 4 | Configured surface count minus one |
| eng_rdy | input | 1 | Engine has a word ready / wants a word |
| eng_data | input | 16 | Word read from the disk |
| eng_done | input | 1 | Engine finished the operation |
| eng_derr | input | 1 | Engine saw a data error (with done) |
| busy | output | 1 | Operation in progress |
| word_rdy | output | 1 | Word ready flag |
| end_rng | output | 1 | End-of-range flag |
| data_err | output | 1 | Data error flag |
| acc_err | output | 1 | Access error flag |
| irq | output | 1 | Interrupt request |
| dma_mode | output | 1 | Operation runs in DMA mode |
| chan_req | output | 1 | Channel request pulse |
| start_vld | output | 1 | Validated start request pulse |
| start_write | output | 1 | Start request direction (1 write) |
| start_surf | output | 4 | Start request surface |
| start_track | output | 6 | Start request track |
| start_caddr | output | 12 | Start request character address |
| xfer_wdata | output | 16 | Buffered output word for the engine |

## Verification
The assertions check, on every cycle, the following cycle-local relations:
- a channel request appears only in DMA mode;
- a start pulse comes only while busy and without an access error;
- nonzero input or output functions are rejected;
- an accepted input clears ready;
- a start while busy keeps the block busy;
- an access error arrives with busy low and the interrupt raised;
- a skip on sense code 1 implies not busy.

Only the directed scenarios can show the following:
- the two-word command sequence;
- the decoded start fields;
- each address-rejection condition, including the 1535/1536 word boundary;
- the read-buffer load from the engine;
- the idle-state output that only clears ready;
- the full sense-code table.

// File: rtl/hpt_pkg.sv
// Shared constants and types of the disk command sequencer.
// Assumes: function codes fit in 4 bits.
package hpt_pkg;
    localparam int FN_START_DMA = 3;
    localparam int FN_START_BUS = 7;
    localparam int FN_TERM      = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CW1  = 2'd1,
        SEQ_CW2  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic start;
        logic start_dma;
        logic term;
        logic out_acc;
        logic in_acc;
    } io_evt_t;
endpackage

// File: rtl/hpt_io_dec.sv
// Strobe decoder: turns the four strobes and their function code into
// events for the sequencer core, and answers skip and reject in the same
// cycle from the current flags. Assumes at most one strobe per cycle.
module hpt_io_dec
    import hpt_pkg::*;
#(
    parameter int FUNC_W = 4
) (
    input  logic              ctl_stb,
    input  logic              out_stb,
    input  logic              in_stb,
    input  logic              sense_stb,
    input  logic [FUNC_W-1:0] func,
    input  logic              ready,
    input  logic              busy,
    input  logic              derr,
    input  logic              aerr,
    input  logic              irq,
    output io_evt_t           evt,
    output logic              skip,
    output logic              reject
);
    // Decode strobes into events and skip/reject responses.
    always_comb begin
        evt    = '0;
        skip   = 1'b0;
        reject = 1'b0;
        if (ctl_stb) begin
            if (func == FUNC_W'(FN_START_DMA)) begin
                evt.start     = 1'b1;
                evt.start_dma = 1'b1;
            end else if (func == FUNC_W'(FN_START_BUS)) begin
                evt.start = 1'b1;
            end else if (func == FUNC_W'(FN_TERM)) begin
                evt.term = 1'b1;
            end else begin
                reject = 1'b1;
            end
        end
        if (out_stb) begin
            if (func != '0) begin
                reject = 1'b1;
            end else if (ready) begin
                evt.out_acc = 1'b1;
                skip        = 1'b1;
            end
        end
        if (in_stb) begin
            if (func != '0) begin
                reject = 1'b1;
            end else if (ready) begin
                evt.in_acc = 1'b1;
                skip       = 1'b1;
            end
        end
        if (sense_stb) begin
            case (func)
                FUNC_W'(0): skip = ready;
                FUNC_W'(1): skip = !busy;
                FUNC_W'(2): skip = !derr;
                FUNC_W'(3): skip = !aerr;
                FUNC_W'(4): skip = !irq;
                default:    skip = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/hpt_addr_chk.sv
// Address checker: validates a second command word against the stored
// surface, unit presence and configured surface count.
// Assumes WORDS_PER_TRACK is representable in CADDR_W-1 bits.
module hpt_addr_chk #(
    parameter int SURF_W          = 4,
    parameter int CADDR_W         = 12,
    parameter int WORDS_PER_TRACK = 1536
) (
    input  logic [CADDR_W-1:1] word_addr,
    input  logic [SURF_W-1:0]  surf,
    input  logic [SURF_W-1:0]  surf_cnt_m1,
    input  logic               unit_present,
    output logic               addr_ok
);
    localparam int WA_W = CADDR_W - 1;
    localparam logic [WA_W-1:0] WA_LIMIT = WA_W'(WORDS_PER_TRACK);

    // All three conditions must hold for an access to proceed.
    always_comb begin
        addr_ok = unit_present && (word_addr < WA_LIMIT) && (surf <= surf_cnt_m1);
    end
endmodule

// File: rtl/hpt_seq_core.sv
// Sequencer core: holds the command-word state machine, the flags, the
// stored command fields and the data buffer. Events from the strobe
// decoder and the transfer engine are applied in one register process;
// engine events are assumed not to coincide with accepted strobes.
module hpt_seq_core
    import hpt_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SURF_W  = 4,
    parameter int TRACK_W = 6,
    parameter int CADDR_W = 12,
    parameter int TRK_LSB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  io_evt_t            evt,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               addr_ok,
    input  logic               chan_assigned,
    input  logic               eng_rdy,
    input  logic [DATA_W-1:0]  eng_data,
    input  logic               eng_done,
    input  logic               eng_derr,
    output logic               busy,
    output logic               ready,
    output logic               eor,
    output logic               derr,
    output logic               aerr,
    output logic               irq,
    output logic               dma,
    output logic               chan_req,
    output logic               start_vld,
    output logic               cmd_write,
    output logic [SURF_W-1:0]  cmd_surf,
    output logic [TRACK_W-1:0] cmd_track,
    output logic [CADDR_W-1:0] cmd_caddr,
    output logic [DATA_W-1:0]  buf_q
);
    localparam int WR_BIT   = DATA_W - 1;
    localparam int SURF_LSB = TRK_LSB + TRACK_W;

    seq_state_t state;
    logic       dma_start;

    // DMA mode is only possible when a channel is attached.
    always_comb begin
        dma_start = evt.start_dma && chan_assigned;
    end

    // Sequencer state, flags, command fields and buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            busy      <= 1'b0;
            ready     <= 1'b0;
            eor       <= 1'b0;
            derr      <= 1'b0;
            aerr      <= 1'b0;
            irq       <= 1'b0;
            dma       <= 1'b0;
            chan_req  <= 1'b0;
            start_vld <= 1'b0;
            cmd_write <= 1'b0;
            cmd_surf  <= '0;
            cmd_track <= '0;
            cmd_caddr <= '0;
            buf_q     <= '0;
        end else begin
            chan_req  <= 1'b0;
            start_vld <= 1'b0;
            if (evt.start && !busy) begin
                busy     <= 1'b1;
                eor      <= 1'b0;
                derr     <= 1'b0;
                aerr     <= 1'b0;
                dma      <= dma_start;
                state    <= SEQ_CW1;
                ready    <= 1'b1;
                chan_req <= dma_start;
            end
            if (evt.term) begin
                eor <= 1'b1;
                irq <= 1'b0;
            end
            if (evt.in_acc) begin
                ready <= 1'b0;
            end
            if (evt.out_acc) begin
                buf_q <= wdata;
                case (state)
                    SEQ_CW1: begin
                        cmd_write <= wdata[WR_BIT];
                        cmd_surf  <= wdata[SURF_LSB +: SURF_W];
                        cmd_track <= wdata[TRK_LSB +: TRACK_W];
                        state     <= SEQ_CW2;
                        chan_req  <= dma;
                    end
                    SEQ_CW2: begin
                        cmd_caddr <= wdata[CADDR_W-1:0];
                        state     <= SEQ_IDLE;
                        if (addr_ok) begin
                            ready     <= cmd_write;
                            chan_req  <= dma && cmd_write;
                            start_vld <= 1'b1;
                        end else begin
                            aerr  <= 1'b1;
                            busy  <= 1'b0;
                            irq   <= 1'b1;
                            ready <= 1'b0;
                        end
                    end
                    default: ready <= 1'b0;
                endcase
            end
            if (eng_rdy) begin
                ready    <= 1'b1;
                chan_req <= dma;
                if (!cmd_write) begin
                    buf_q <= eng_data;
                end
            end
            if (eng_done) begin
                busy <= 1'b0;
                irq  <= 1'b1;
                if (eng_derr) begin
                    derr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hpt_cmd_seq.sv
// Top of the disk command sequencer: wires the strobe decoder, the
// address checker and the sequencer core. Assumes single-cycle strobes.
module hpt_cmd_seq
    import hpt_pkg::*;
#(
    parameter int DATA_W          = 16,
    parameter int FUNC_W          = 4,
    parameter int SURF_W          = 4,
    parameter int TRACK_W         = 6,
    parameter int CADDR_W         = 12,
    parameter int TRK_LSB         = 4,
    parameter int WORDS_PER_TRACK = 1536
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_stb,
    input  logic               out_stb,
    input  logic               in_stb,
    input  logic               sense_stb,
    input  logic [FUNC_W-1:0]  func,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               skip,
    output logic               reject,
    input  logic               chan_assigned,
    input  logic               unit_present,
    input  logic [SURF_W-1:0]  surf_cnt_m1,
    input  logic               eng_rdy,
    input  logic [DATA_W-1:0]  eng_data,
    input  logic               eng_done,
    input  logic               eng_derr,
    output logic               busy,
    output logic               word_rdy,
    output logic               end_rng,
    output logic               data_err,
    output logic               acc_err,
    output logic               irq,
    output logic               dma_mode,
    output logic               chan_req,
    output logic               start_vld,
    output logic               start_write,
    output logic [SURF_W-1:0]  start_surf,
    output logic [TRACK_W-1:0] start_track,
    output logic [CADDR_W-1:0] start_caddr,
    output logic [DATA_W-1:0]  xfer_wdata
);
    io_evt_t evt;
    logic    addr_ok;

    hpt_io_dec #(.FUNC_W(FUNC_W)) u_dec (
        .ctl_stb(ctl_stb), .out_stb(out_stb), .in_stb(in_stb),
        .sense_stb(sense_stb), .func(func), .ready(word_rdy),
        .busy(busy), .derr(data_err), .aerr(acc_err), .irq(irq),
        .evt(evt), .skip(skip), .reject(reject)
    );

    hpt_addr_chk #(
        .SURF_W(SURF_W), .CADDR_W(CADDR_W), .WORDS_PER_TRACK(WORDS_PER_TRACK)
    ) u_chk_addr (
        .word_addr(wdata[CADDR_W-1:1]), .surf(start_surf),
        .surf_cnt_m1(surf_cnt_m1), .unit_present(unit_present),
        .addr_ok(addr_ok)
    );

    hpt_seq_core #(
        .DATA_W(DATA_W), .SURF_W(SURF_W), .TRACK_W(TRACK_W),
        .CADDR_W(CADDR_W), .TRK_LSB(TRK_LSB)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .evt(evt), .wdata(wdata),
        .addr_ok(addr_ok), .chan_assigned(chan_assigned),
        .eng_rdy(eng_rdy), .eng_data(eng_data), .eng_done(eng_done),
        .eng_derr(eng_derr), .busy(busy), .ready(word_rdy),
        .eor(end_rng), .derr(data_err), .aerr(acc_err), .irq(irq),
        .dma(dma_mode), .chan_req(chan_req), .start_vld(start_vld),
        .cmd_write(start_write), .cmd_surf(start_surf),
        .cmd_track(start_track), .cmd_caddr(start_caddr),
        .buf_q(xfer_wdata)
    );

    // Return the buffer only on an accepted input strobe.
    always_comb begin
        rdata = evt.in_acc ? xfer_wdata : '0;
    end
endmodule

// File: rtl/hpt_seq_chk.sv
// Checker for the disk command sequencer, bound to the top module.
module hpt_seq_chk #(
    parameter int FUNC_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_stb,
    input logic              out_stb,
    input logic              in_stb,
    input logic              sense_stb,
    input logic [FUNC_W-1:0] func,
    input logic              skip,
    input logic              reject,
    input logic              busy,
    input logic              word_rdy,
    input logic              irq,
    input logic              acc_err,
    input logic              dma_mode,
    input logic              chan_req,
    input logic              start_vld,
    input logic              eng_rdy,
    input logic              eng_done
);
    assert_chanreq_dma_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_req |-> dma_mode);

    assert_start_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_vld |-> (busy && !acc_err));

    assert_badfunc_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_stb || in_stb) && func != '0) |-> reject);

    assert_input_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && func == '0 && word_rdy && !eng_rdy) |=> !word_rdy);

    assert_access_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> (!busy && irq));

    assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_stb && (func == FUNC_W'(3) || func == FUNC_W'(7)) && busy && !eng_done) |=> busy);

    assert_sense_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_stb && func == FUNC_W'(1) && skip) |-> !busy);
endmodule

bind hpt_cmd_seq hpt_seq_chk #(.FUNC_W(FUNC_W)) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .ctl_stb(ctl_stb), .out_stb(out_stb),
    .in_stb(in_stb), .sense_stb(sense_stb), .func(func), .skip(skip),
    .reject(reject), .busy(busy), .word_rdy(word_rdy), .irq(irq),
    .acc_err(acc_err), .dma_mode(dma_mode), .chan_req(chan_req),
    .start_vld(start_vld), .eng_rdy(eng_rdy), .eng_done(eng_done)
);

// File: tb/hpt_cmd_seq_test.sv
`timescale 1ns/1ps
module hpt_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_stb = 0, out_stb = 0, in_stb = 0, sense_stb = 0;
    logic [3:0]  func = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        skip, reject;
    logic        chan_assigned = 1'b1, unit_present = 1'b1;
    logic [3:0]  surf_cnt_m1 = 4'd3;
    logic        eng_rdy = 0, eng_done = 0, eng_derr = 0;
    logic [15:0] eng_data = '0;
    logic        busy, word_rdy, end_rng, data_err, acc_err, irq;
    logic        dma_mode, chan_req, start_vld, start_write;
    logic [3:0]  start_surf;
    logic [5:0]  start_track;
    logic [11:0] start_caddr;
    logic [15:0] xfer_wdata;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic        g_skip, g_rej;
    logic [15:0] g_rdata;

    localparam int K_CTL = 0, K_OUT = 1, K_IN = 2, K_SNS = 3;

    always #2.5 clk = ~clk;

    hpt_cmd_seq uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One strobe cycle; comb responses are captured before the edge.
    task automatic io(input int kind, input logic [3:0] fn, input logic [15:0] d);
        @(negedge clk);
        ctl_stb   = (kind == K_CTL);
        out_stb   = (kind == K_OUT);
        in_stb    = (kind == K_IN);
        sense_stb = (kind == K_SNS);
        func = fn;
        wdata = d;
        #1;
        g_skip = skip;
        g_rej = reject;
        g_rdata = rdata;
        @(posedge clk);
        #1;
        ctl_stb = 0; out_stb = 0; in_stb = 0; sense_stb = 0;
    endtask

    task automatic eng(input logic r, input logic dn, input logic de, input logic [15:0] d);
        @(negedge clk);
        eng_rdy = r; eng_done = dn; eng_derr = de; eng_data = d;
        @(posedge clk);
        #1;
        eng_rdy = 0; eng_done = 0; eng_derr = 0;
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 ready", word_rdy, 0);
        check("R1 flags", {end_rng, data_err, acc_err, irq}, 0);
        check("R1 dma/pulses", {dma_mode, chan_req, start_vld}, 0);
        io(K_SNS, 4'd1, 0);
        check("R1 R7 sense not busy", g_skip, 1);
    endtask

    task automatic t_read_bus();
        io(K_CTL, 4'd7, 0);
        check("R3 busy", busy, 1);
        check("R3 ready", word_rdy, 1);
        check("R4 bus mode no dma", {dma_mode, chan_req}, 0);
        io(K_OUT, 4'd0, 16'h0850);              // read, surface 2, track 5
        check("R5 cw1 skip", g_skip, 1);
        check("R5 cw1 ready kept", word_rdy, 1);
        io(K_OUT, 4'd0, 16'h0123);
        check("R10 start pulse", start_vld, 1);
        check("R10 read clears ready", word_rdy, 0);
        check("R8 fields", {start_write, start_surf, start_track, start_caddr},
              {1'b0, 4'd2, 6'd5, 12'h123});
        eng(1, 0, 0, 16'hBEEF);
        check("R11 ready set", word_rdy, 1);
        io(K_SNS, 4'd0, 0);
        check("R7 sense ready", g_skip, 1);
        io(K_IN, 4'd0, 0);
        check("R6 input skip", g_skip, 1);
        check("R6 R11 input data", g_rdata, 16'hBEEF);
        check("R6 ready cleared", word_rdy, 0);
        io(K_IN, 4'd0, 0);
        check("R6 no skip without ready", g_skip, 0);
        eng(0, 1, 1, 0);
        check("R11 done", {busy, irq, data_err}, 3'b011);
        io(K_SNS, 4'd2, 0);
        check("R7 sense data err", g_skip, 0);
        io(K_SNS, 4'd4, 0);
        check("R7 sense irq pending", g_skip, 0);
        io(K_CTL, 4'd4, 0);
        check("R2 terminate", {end_rng, irq}, 2'b10);
        io(K_SNS, 4'd4, 0);
        check("R7 sense no irq", g_skip, 1);
    endtask

    task automatic t_write_dma();
        io(K_CTL, 4'd3, 0);
        check("R3 clears eor/derr", {end_rng, data_err}, 0);
        check("R4 dma start", {dma_mode, chan_req}, 2'b11);
        io(K_OUT, 4'd0, 16'h8010);              // write, surface 0, track 1
        check("R4 chan req after cw1", chan_req, 1);
        io(K_CTL, 4'd7, 0);
        check("R3 start ignored busy", {busy, dma_mode, chan_req}, 3'b110);
        io(K_OUT, 4'd0, 16'h0004);
        check("R10 write start", {start_vld, word_rdy, start_write}, 3'b111);
        check("R4 chan req write", chan_req, 1);
        io(K_OUT, 4'd0, 16'h1234);
        check("R5 idle output clears ready", {g_skip, word_rdy}, 2'b10);
        check("R5 buffered word", xfer_wdata, 16'h1234);
        io(K_OUT, 4'd0, 16'h9999);
        check("R5 output not ready", {g_skip, xfer_wdata}, {1'b0, 16'h1234});
        eng(1, 0, 0, 16'h7777);
        check("R11 R4 write ready", {word_rdy, chan_req, xfer_wdata}, {2'b11, 16'h1234});
        eng(0, 1, 0, 0);
        check("R11 done no derr", {busy, data_err}, 0);
    endtask

    task automatic t_access();
        io(K_CTL, 4'd7, 0);
        io(K_OUT, 4'd0, 16'h1400);              // surface 5 > 3
        io(K_OUT, 4'd0, 16'h0010);
        check("R9 bad surface", {acc_err, busy, irq, word_rdy, start_vld}, 5'b10100);
        io(K_SNS, 4'd3, 0);
        check("R7 sense access err", g_skip, 0);
        io(K_CTL, 4'd3, 0);
        check("R3 clears access err", acc_err, 0);
        io(K_OUT, 4'd0, 16'h0C00);              // surface 3, track 0
        io(K_OUT, 4'd0, 16'h0BFF);              // word 1535
        check("R9 word 1535 valid", {start_vld, acc_err}, 2'b10);
        eng(0, 1, 0, 0);
        io(K_CTL, 4'd7, 0);
        io(K_OUT, 4'd0, 16'h0C00);
        io(K_OUT, 4'd0, 16'h0C00);              // word 1536
        check("R9 word 1536", {acc_err, busy, start_vld}, 3'b100);
        unit_present = 1'b0;
        io(K_CTL, 4'd7, 0);
        io(K_OUT, 4'd0, 16'h0000);
        io(K_OUT, 4'd0, 16'h0000);
        check("R9 unit absent", {acc_err, start_vld}, 2'b10);
        unit_present = 1'b1;
        chan_assigned = 1'b0;
        io(K_CTL, 4'd3, 0);
        check("R4 no channel", {dma_mode, chan_req}, 0);
        chan_assigned = 1'b1;
    endtask

    task automatic t_reject();
        io(K_CTL, 4'd5, 0);
        check("R2 bad control", g_rej, 1);
        io(K_OUT, 4'd1, 0);
        check("R6 bad output func", {g_rej, g_skip}, 2'b10);
        io(K_IN, 4'd2, 0);
        check("R6 bad input func", g_rej, 1);
        io(K_SNS, 4'd6, 0);
        check("R7 unknown sense", {g_rej, g_skip}, 0);
    endtask

    // Watchdog: count cycles and end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_bus();
        t_write_dma();
        t_access();
        t_reject();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule